// File: doc/BRIEF.md
# Floating-Point Condition Predicate Evaluator

This block decides whether a floating-point conditional test passes. A 4-bit predicate code selects one of sixteen tests. The block applies that test to three condition flags that an earlier compare or arithmetic step left behind: negative, zero and not-a-number. The result comes out combinationally, in the same cycle as the inputs, so a branch, set or trap unit can use it at once.

Any predicate may be issued in a signaling form. A signaling test on an unordered operand (the NaN flag is set) counts as an invalid comparison. One cycle after the evaluation, the block pulses two set strobes. One is for the unordered-branch exception-status bit, the other for the invalid-operation accrued bit. If the unordered-branch exception is enabled, the block also raises an exception request with its vector number, and it forces the predicate result to false for that evaluation. The status register and the exception frame logic live outside this block and only consume these pulses.

The predicate field is six bits wide. Only its low four bits choose the test.

Top module: `fpcc_eval`

## Requirements
- R1: Code 0 gives false and code 15 gives true, whatever the flags. Code 1 gives Z and code 14 gives not Z.
- R2: Code 2 (greater) is true only when NaN, Z and N are all clear. Code 3 (greater or equal) is true when Z is set, or when both NaN and N are clear.
- R3: Code 4 (less) is true when N is set and both NaN and Z are clear. Code 5 (less or equal) is true when Z is set, or when N is set and NaN is clear.
- R4: Code 6 is true when NaN and Z are both clear. Code 7 is true when NaN is clear. Code 8 is true when NaN is set.
- R5: Codes 9 to 13 are true whenever NaN is set. Otherwise they give, in order: Z; not (N or Z); Z or not N; N and not Z; Z or N.
- R6: Bits 5 and 4 of `predCode` have no effect on `condTrue`.
- R7: If `evalValid`, `signaling` and `ccNan` are all high in a cycle, then `setBsunStatus` and `setIopAccrued` are both high in the next cycle. This holds whether or not the exception is enabled. Each such evaluation gives one pulse of one cycle.
- R8: If `bsunEnable` is also high in that evaluation, `excReq` is high in the next cycle with `excVector` equal to 48. Also, while `signaling`, `ccNan` and `bsunEnable` are all high, `condTrue` reads 0.
- R9: If `bsunEnable` is low, a signaling unordered evaluation raises no `excReq`, and `condTrue` keeps its normal predicate value.
- R10: No strobe and no request follows a cycle where `evalValid`, `signaling` or `ccNan` is low.
- R11: While reset is asserted (`rst_n` low), and in the first cycle after it, all strobes are 0 and `excVector` is 0.
- R12: `excVector` is 0 whenever `excReq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evalValid | input | 1 | An evaluation takes place this cycle |
| predCode | input | 6 | Predicate field; only the low 4 bits select the test |
| signaling | input | 1 | Treat an unordered operand as an exception condition |
| ccNeg | input | 1 | Negative condition flag |
| ccZero | input | 1 | Zero condition flag |
| ccNan | input | 1 | Not-a-number (unordered) condition flag |
| bsunEnable | input | 1 | Unordered-branch exception enabled |
| condTrue | output | 1 | Predicate result, combinational |
| setBsunStatus | output | 1 | One-cycle pulse that sets the exception-status bit |
| setIopAccrued | output | 1 | One-cycle pulse that sets the invalid-operation accrued bit |
| excReq | output | 1 | One-cycle exception request |
| excVector | output | 8 | Vector number during a request, 0 otherwise |

## Verification
The clocked assertions assume that every input is settled and known at each rising edge. They also assume that the flags describe a single operand state, so N and Z are never both set together with NaN in a way the predicates would need to resolve. The stimulus changes inputs only on falling edges. It sets at most one of Z and NaN in the directed checks. The full sweep does cover all eight flag patterns, but with `evalValid` and `signaling` held low, so no exception path is active. Strobe checks are sampled one falling edge after the evaluation, and again one edge later, to confirm that each pulse is a single cycle long.

// File: rtl/fpcc_pkg.sv
package fpcc_pkg;

  // Strobes from control to datapath.
  typedef struct packed {
    logic suppress;    // combinational: force result false
    logic raiseNow;    // combinational: exception condition this cycle
    logic setStatus;   // registered pulse
    logic setAccrued;  // registered pulse
    logic excReq;      // registered pulse
  } bsunCtl_t;

endpackage

// File: rtl/fpcc_ctrl.sv
module fpcc_ctrl
  import fpcc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     evalValid,
  input  logic     signaling,
  input  logic     ccNan,
  input  logic     bsunEnable,
  output bsunCtl_t ctl
);

  logic unorderedHit;
  logic statusQ, accruedQ, excQ;

  assign unorderedHit = evalValid & signaling & ccNan;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      statusQ  <= 1'b0;
      accruedQ <= 1'b0;
      excQ     <= 1'b0;
    end else begin
      statusQ  <= unorderedHit;
      accruedQ <= unorderedHit;
      excQ     <= unorderedHit & bsunEnable;
    end
  end

  always_comb begin
    ctl            = '0;
    ctl.suppress   = signaling & ccNan & bsunEnable;
    ctl.raiseNow   = unorderedHit & bsunEnable;
    ctl.setStatus  = statusQ;
    ctl.setAccrued = accruedQ;
    ctl.excReq     = excQ;
  end

  // R7: a signaling unordered evaluation sets both bits next cycle
  p_bsun_bits_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (evalValid && signaling && ccNan) |=> (ctl.setStatus && ctl.setAccrued));

  // R8: enabled exception raises a request next cycle
  p_exc_raise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (evalValid && signaling && ccNan && bsunEnable) |=> ctl.excReq);

  // R9: no request without enable
  p_exc_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (evalValid && signaling && ccNan && !bsunEnable) |=> !ctl.excReq);

  // R10: quiet when the trigger is absent
  p_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(evalValid && signaling && ccNan) |=> !(ctl.setStatus || ctl.setAccrued || ctl.excReq));

endmodule

// File: rtl/fpcc_dp.sv
module fpcc_dp
  import fpcc_pkg::*;
#(
  parameter int CODE_W      = 6,
  parameter int SEL_W       = 4,
  parameter int VEC_W       = 8,
  parameter int BSUN_VECTOR = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] predCode,
  input  logic              ccNeg,
  input  logic              ccZero,
  input  logic              ccNan,
  input  bsunCtl_t          ctl,
  output logic              condTrue,
  output logic [VEC_W-1:0]  excVector
);

  localparam int NUM_PRED = 1 << SEL_W;
  localparam logic [VEC_W-1:0] VEC_VAL = VEC_W'(BSUN_VECTOR);

  function automatic logic predicateOf(input logic [3:0] sel,
                                       input logic n, input logic z, input logic u);
    logic r;
    unique case (sel)
      4'd0:  r = 1'b0;
      4'd1:  r = z;
      4'd2:  r = ~(u | z | n);
      4'd3:  r = z | ~(u | n);
      4'd4:  r = n & ~(u | z);
      4'd5:  r = z | (n & ~u);
      4'd6:  r = ~(u | z);
      4'd7:  r = ~u;
      4'd8:  r = u;
      4'd9:  r = u | z;
      4'd10: r = u | ~(n | z);
      4'd11: r = u | z | ~n;
      4'd12: r = u | (n & ~z);
      4'd13: r = u | z | n;
      4'd14: r = ~z;
      default: r = 1'b1;
    endcase
    return r;
  endfunction

  logic [NUM_PRED-1:0] predVec;
  logic [SEL_W-1:0]    sel;
  logic [VEC_W-1:0]    vecQ;

  generate
    for (genvar i = 0; i < NUM_PRED; i++) begin : g_pred
      assign predVec[i] = predicateOf(4'(i), ccNeg, ccZero, ccNan);
    end
  endgenerate

  assign sel      = predCode[SEL_W-1:0];
  assign condTrue = predVec[sel] & ~ctl.suppress;

  always_ff @(posedge clk) begin
    if (!rst_n) vecQ <= '0;
    else        vecQ <= ctl.raiseNow ? VEC_VAL : '0;
  end

  assign excVector = vecQ;

  // R1: code 0 never true
  p_const_false_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (predCode[3:0] == 4'd0) |-> !condTrue);

  // R8: suppression forces false
  p_suppress_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.suppress |-> !condTrue);

  // R12: vector flop agrees with request flop in the control
  p_vec_match_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.excReq == (excVector == VEC_VAL));

  p_vec_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.excReq |-> (excVector == '0));

endmodule

// File: rtl/fpcc_eval.sv
module fpcc_eval
  import fpcc_pkg::*;
#(
  parameter int CODE_W      = 6,
  parameter int SEL_W       = 4,
  parameter int VEC_W       = 8,
  parameter int BSUN_VECTOR = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evalValid,
  input  logic [CODE_W-1:0] predCode,
  input  logic              signaling,
  input  logic              ccNeg,
  input  logic              ccZero,
  input  logic              ccNan,
  input  logic              bsunEnable,
  output logic              condTrue,
  output logic              setBsunStatus,
  output logic              setIopAccrued,
  output logic              excReq,
  output logic [VEC_W-1:0]  excVector
);

  bsunCtl_t ctl;

  fpcc_ctrl ctrl_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .evalValid  (evalValid),
    .signaling  (signaling),
    .ccNan      (ccNan),
    .bsunEnable (bsunEnable),
    .ctl        (ctl)
  );

  fpcc_dp #(
    .CODE_W      (CODE_W),
    .SEL_W       (SEL_W),
    .VEC_W       (VEC_W),
    .BSUN_VECTOR (BSUN_VECTOR)
  ) dp_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .predCode  (predCode),
    .ccNeg     (ccNeg),
    .ccZero    (ccZero),
    .ccNan     (ccNan),
    .ctl       (ctl),
    .condTrue  (condTrue),
    .excVector (excVector)
  );

  assign setBsunStatus = ctl.setStatus;
  assign setIopAccrued = ctl.setAccrued;
  assign excReq        = ctl.excReq;

endmodule

// File: tb/fpcc_eval_tb_top.sv
module fpcc_eval_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       evalValid = 1'b0;
  logic [5:0] predCode = '0;
  logic       signaling = 1'b0;
  logic       ccNeg = 1'b0, ccZero = 1'b0, ccNan = 1'b0;
  logic       bsunEnable = 1'b0;
  logic       condTrue, setBsunStatus, setIopAccrued, excReq;
  logic [7:0] excVector;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  fpcc_eval dut_i (
    .clk(clk), .rst_n(rst_n), .evalValid(evalValid), .predCode(predCode),
    .signaling(signaling), .ccNeg(ccNeg), .ccZero(ccZero), .ccNan(ccNan),
    .bsunEnable(bsunEnable), .condTrue(condTrue), .setBsunStatus(setBsunStatus),
    .setIopAccrued(setIopAccrued), .excReq(excReq), .excVector(excVector)
  );

  // Fields: req[13:10] code[9:4] n[3] z[2] nan[1] expected[0]
  localparam int NV = 25;
  localparam logic [13:0] VEC [NV] = '{
    {4'd1, 6'd0,  1'b0,1'b1,1'b0, 1'b0},  // R1
    {4'd1, 6'd15, 1'b0,1'b0,1'b1, 1'b1},  // R1
    {4'd1, 6'd1,  1'b0,1'b1,1'b0, 1'b1},  // R1
    {4'd1, 6'd14, 1'b0,1'b1,1'b0, 1'b0},  // R1
    {4'd1, 6'd14, 1'b1,1'b0,1'b0, 1'b1},  // R1
    {4'd2, 6'd2,  1'b0,1'b0,1'b0, 1'b1},  // R2
    {4'd2, 6'd2,  1'b0,1'b0,1'b1, 1'b0},  // R2
    {4'd2, 6'd3,  1'b0,1'b1,1'b0, 1'b1},  // R2
    {4'd2, 6'd3,  1'b1,1'b0,1'b0, 1'b0},  // R2
    {4'd3, 6'd4,  1'b1,1'b0,1'b0, 1'b1},  // R3
    {4'd3, 6'd4,  1'b1,1'b0,1'b1, 1'b0},  // R3
    {4'd3, 6'd5,  1'b1,1'b0,1'b0, 1'b1},  // R3
    {4'd3, 6'd5,  1'b1,1'b0,1'b1, 1'b0},  // R3
    {4'd4, 6'd6,  1'b1,1'b0,1'b0, 1'b1},  // R4
    {4'd4, 6'd6,  1'b0,1'b1,1'b0, 1'b0},  // R4
    {4'd4, 6'd7,  1'b0,1'b0,1'b1, 1'b0},  // R4
    {4'd4, 6'd8,  1'b0,1'b0,1'b1, 1'b1},  // R4
    {4'd5, 6'd9,  1'b0,1'b0,1'b1, 1'b1},  // R5
    {4'd5, 6'd10, 1'b0,1'b0,1'b0, 1'b1},  // R5
    {4'd5, 6'd10, 1'b1,1'b0,1'b0, 1'b0},  // R5
    {4'd5, 6'd11, 1'b1,1'b0,1'b0, 1'b0},  // R5
    {4'd5, 6'd12, 1'b1,1'b0,1'b0, 1'b1},  // R5
    {4'd5, 6'd13, 1'b0,1'b0,1'b0, 1'b0},  // R5
    {4'd5, 6'd13, 1'b1,1'b0,1'b1, 1'b1},  // R5
    {4'd6, 6'h32, 1'b0,1'b0,1'b0, 1'b1}   // R6: upper bits set on code 2
  };

  // Independent reference written from R1..R5
  function automatic logic refPred(input int c, input logic n, input logic z, input logic u);
    if (c == 0) return 1'b0;
    if (c == 15) return 1'b1;
    if (c == 1) return z;
    if (c == 14) return !z;
    if (c >= 9 && c <= 13 && u) return 1'b1;
    case (c)
      2: return !u && !z && !n;
      3: return z || (!u && !n);
      4: return n && !u && !z;
      5: return z || (n && !u);
      6: return !u && !z;
      7: return !u;
      8: return u;
      9: return z;
      10: return !(n || z);
      11: return z || !n;
      12: return n && !z;
      default: return z || n;
    endcase
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic chkStrobes(input string req, input int st, input int ac, input int ex, input int vec);
    chk(req, "setBsunStatus", int'(setBsunStatus), st);
    chk(req, "setIopAccrued", int'(setIopAccrued), ac);
    chk(req, "excReq", int'(excReq), ex);
    chk(req, "excVector", int'(excVector), vec);
  endtask

  task automatic finishRun();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // Drive one evaluation at a falling edge, check result, then check strobes.
  task automatic evalOnce(input string req, input logic [5:0] code, input logic sig,
                          input logic n, input logic z, input logic u, input logic en,
                          input logic vld, input int expCond, input int expSt,
                          input int expEx);
    @(negedge clk);
    predCode = code; signaling = sig; ccNeg = n; ccZero = z; ccNan = u;
    bsunEnable = en; evalValid = vld;
    #1;
    chk(req, "condTrue", int'(condTrue), expCond);
    @(negedge clk);
    chkStrobes(req, expSt, expSt, expEx, expEx ? 48 : 0);
    evalValid = 1'b0; signaling = 1'b0; ccNan = 1'b0; bsunEnable = 1'b0;
    @(negedge clk);
    chkStrobes(req, 0, 0, 0, 0);  // single-cycle pulse
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      finishRun();
    end
  end

  initial begin
    // R11: reset state, including an input that would trigger strobes
    evalValid = 1'b1; signaling = 1'b1; ccNan = 1'b1; bsunEnable = 1'b1;
    repeat (3) @(negedge clk);
    chkStrobes("R11", 0, 0, 0, 0);
    evalValid = 1'b0; signaling = 1'b0; ccNan = 1'b0; bsunEnable = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chkStrobes("R11", 0, 0, 0, 0);

    // Table walk
    for (int i = 0; i < NV; i++) begin
      predCode = VEC[i][9:4];
      ccNeg = VEC[i][3]; ccZero = VEC[i][2]; ccNan = VEC[i][1];
      #1;
      chk($sformatf("R%0d", VEC[i][13:10]), $sformatf("condTrue code %0d", VEC[i][9:4]),
          int'(condTrue), int'(VEC[i][0]));
    end

    // Full sweep against the reference; upper bits vary too (R6)
    for (int c = 0; c < 64; c++) begin
      for (int f = 0; f < 8; f++) begin
        predCode = 6'(c); ccNeg = f[2]; ccZero = f[1]; ccNan = f[0];
        #1;
        chk("R1-R6 sweep", $sformatf("code %0d flags %0d", c, f), int'(condTrue),
            int'(refPred(c % 16, f[2], f[1], f[0])));
      end
    end
    ccNeg = 1'b0; ccZero = 1'b0; ccNan = 1'b0;

    // R7 and R9: signaling unordered, exception disabled, result kept
    evalOnce("R7", 6'd8, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1, 1, 0);
    evalOnce("R9", 6'd13, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1, 1, 0);
    // R8: enabled, request with vector, result suppressed
    evalOnce("R8", 6'd15, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 0, 1, 1);
    evalOnce("R8", 6'd8, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 0, 1, 1);
    // R10: each trigger term removed in turn
    evalOnce("R10", 6'd15, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1, 0, 0);
    evalOnce("R10", 6'd8, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1, 0, 0);
    evalOnce("R10", 6'd8, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1, 0, 0);

    // R7: back-to-back evaluations give one pulse each
    @(negedge clk);
    predCode = 6'd8; signaling = 1'b1; ccNan = 1'b1; evalValid = 1'b1; bsunEnable = 1'b1;
    @(negedge clk);
    chkStrobes("R7", 1, 1, 1, 48);
    bsunEnable = 1'b0;
    @(negedge clk);
    chkStrobes("R7", 1, 1, 0, 0);  // R12: vector cleared without request
    evalValid = 1'b0; signaling = 1'b0; ccNan = 1'b0;
    @(negedge clk);
    chkStrobes("R12", 0, 0, 0, 0);

    done = 1'b1;
    finishRun();
  end

endmodule